// File: doc/BRIEF.md
# Serial Bit-Rate Timing Generator

This block turns a peripheral clock into the timing enables a serial port needs. A two-bit clock-select input picks a coarse prescaler. An eight-bit rate value N then divides the prescaled clock by N+1. A mode input chooses between two kinds of timing. Asynchronous mode produces a sixteen-times oversampling enable and a bit enable. Clocked-synchronous mode produces a serial clock level, a half-period toggle enable and a bit enable. Every output is a one-cycle enable or a registered level, so no derived clock net exists.

The block restarts from a clean zero phase in three cases: the enable goes low, or the rate, clock-select or mode inputs change. A receiver or transmitter shifter can then be paired with it without any phase left over from the old setting.

Top module: `serial_baud_gen`

## Requirements
- R1: With prescale factor P and rate value N, let U = 2·P·(N+1). In asynchronous mode (`mode`=0), `os_tick` is high for one cycle after every U-th consecutive active clock edge. An active edge is one where `en` is high and the configuration is unchanged from the previous edge. The first pulse follows the U-th active edge after a restart.
- R2: The `clk_sel` codes give these prescale factors P: 2'b00 gives 1, 2'b01 gives 8, 2'b10 gives 32 and 2'b11 gives 128.
- R3: In asynchronous mode, `bit_tick` is high on every 16th `os_tick`, in the same cycle as that tick. One bit therefore lasts 32·P·(N+1) clocks.
- R4: In synchronous mode (`mode`=1), `sclk` starts low after a restart and toggles every U clocks. `sclk_edge` is high for one cycle, in the same cycle as each toggle.
- R5: In synchronous mode, `bit_tick` is high exactly in the cycles where `sclk` has just risen. One bit therefore lasts 4·P·(N+1) clocks.
- R6: A change of `rate`, `clk_sel` or `mode` clears all counters and `sclk`. On the next clock edge all outputs are low, and timing restarts from zero.
- R7: While `en` is low, every output is low after each clock edge, and `sclk` included.
- R8: `os_tick` never pulses in synchronous mode. `sclk_edge` and `sclk` never go high in asynchronous mode.
- R9: The fastest setting (synchronous mode, N=0, `clk_sel`=2'b00) toggles `sclk` every 2 clocks. Its enables stay single-cycle.
- R10: After an active-low reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the generator cleared |
| mode | input | 1 | 0 = asynchronous, 1 = clocked synchronous |
| clk_sel | input | 2 | Prescaler select |
| rate | input | RATE_W (8) | Divider value N |
| os_tick | output | 1 | Oversampling enable (asynchronous) |
| bit_tick | output | 1 | Bit boundary enable |
| sclk | output | 1 | Serial clock level (synchronous) |
| sclk_edge | output | 1 | Serial clock toggle enable (synchronous) |

## Verification
Some properties are checked by assertions on every cycle. The prescaler and divider counters stay inside their limits. The two modes never share an enable. `sclk` only rises together with a toggle enable. In synchronous mode a bit enable comes only with a rising `sclk`. The outputs stay quiet while disabled. The exact periods show up only in the bench scenarios, which compare every output on every cycle against an active-edge count model. These are U, the 16-tick bit grouping and the position of the first pulse after a restart. The scenarios mix random settings with directed cases: the largest prescaler, N=255, the fastest synchronous setting and configuration changes mid-count.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } brg_mode_e;

  localparam int PRE_W = 7;

  // Terminal count of the prescaler, i.e. factor minus one.
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    logic [PRE_W-1:0] lim;
    case (sel)
      2'd0:    lim = PRE_W'(0);
      2'd1:    lim = PRE_W'(7);
      2'd2:    lim = PRE_W'(31);
      default: lim = PRE_W'(127);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
  parameter int CNT_W = brg_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             pre_tick
);
  logic [CNT_W-1:0] cnt_q;

  assign pre_tick = !clr && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (cnt_q == limit) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> cnt_q <= limit); // R2

endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [RATE_W-1:0] rate,
  output logic              unit_tick
);
  logic [RATE_W-1:0] cnt_q;
  logic              half_q;
  logic              wrap;

  assign wrap      = step && (cnt_q == rate);
  assign unit_tick = wrap && half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else if (step) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> cnt_q <= rate); // R1

endmodule

// File: rtl/brg_phase.sv
module brg_phase #(
  parameter int OS_RATIO = 16,
  localparam int OS_W = $clog2(OS_RATIO)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              unit,
  input  brg_pkg::brg_mode_e mode,
  output logic              os_tick_o,
  output logic              bit_tick_o,
  output logic              sclk_o,
  output logic              sclk_edge_o
);
  import brg_pkg::*;

  logic [OS_W-1:0] os_cnt_q;
  logic            async_unit;
  logic            sync_unit;

  assign async_unit = unit && (mode == MODE_ASYNC);
  assign sync_unit  = unit && (mode == MODE_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      os_cnt_q    <= '0;
      os_tick_o   <= 1'b0;
      bit_tick_o  <= 1'b0;
      sclk_o      <= 1'b0;
      sclk_edge_o <= 1'b0;
    end else begin
      os_tick_o   <= async_unit;
      sclk_edge_o <= sync_unit;
      bit_tick_o  <= (async_unit && os_cnt_q == OS_W'(OS_RATIO-1))
                  || (sync_unit && !sclk_o);
      if (async_unit) os_cnt_q <= os_cnt_q + 1'b1;
      if (sync_unit)  sclk_o   <= ~sclk_o;
    end
  end

  AST_SCLK_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> sclk_edge_o); // R4

  AST_SYNC_BIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick_o && sclk_edge_o) |-> (sclk_o && !$past(sclk_o))); // R5

endmodule

// File: rtl/serial_baud_gen.sv
module serial_baud_gen #(
  parameter int RATE_W   = 8,
  parameter int OS_RATIO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mode,
  input  logic [1:0]        clk_sel,
  input  logic [RATE_W-1:0] rate,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              sclk,
  output logic              sclk_edge
);
  import brg_pkg::*;

  localparam int CFG_W = RATE_W + 3;

  logic [CFG_W-1:0] cfg;
  logic [CFG_W-1:0] cfg_q;
  logic             clr;
  logic             pre_tick;
  logic             unit_tick;
  brg_mode_e        mode_e;

  assign cfg    = {mode, clk_sel, rate};
  assign clr    = !en || (cfg != cfg_q);
  assign mode_e = brg_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg;
  end

  brg_prescaler #(.CNT_W(PRE_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .limit(pre_limit(clk_sel)), .pre_tick(pre_tick)
  );

  brg_divider #(.RATE_W(RATE_W)) i_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(pre_tick),
    .rate(rate), .unit_tick(unit_tick)
  );

  brg_phase #(.OS_RATIO(OS_RATIO)) i_phase (
    .clk(clk), .rst_n(rst_n), .clr(clr), .unit(unit_tick), .mode(mode_e),
    .os_tick_o(os_tick), .bit_tick_o(bit_tick),
    .sclk_o(sclk), .sclk_edge_o(sclk_edge)
  );

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(os_tick && sclk_edge)); // R8

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> !(os_tick || bit_tick || sclk || sclk_edge)); // R7

endmodule

// File: tb/test_serial_baud_gen.sv
module test_serial_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [7:0] rate = 8'd0;
  logic       os_tick, bit_tick, sclk, sclk_edge;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  // model state
  int  act_idx = 0;
  logic [10:0] prev_cfg = '0;
  logic e_os, e_bit, e_sclk, e_edge;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_baud_gen i_serial_baud_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .clk_sel(clk_sel),
    .rate(rate), .os_tick(os_tick), .bit_tick(bit_tick),
    .sclk(sclk), .sclk_edge(sclk_edge)
  );

  function automatic int pfac(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (1 << (2 * int'(s) + 1));
  endfunction

  function automatic int unit_len(input logic [1:0] s, input logic [7:0] n);
    return 2 * pfac(s) * (int'(n) + 1);
  endfunction

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b (mode=%b sel=%0d N=%0d)",
               tag, cycles, act, exp, mode, clk_sel, rate);
    end
  endtask

  // one clock: inputs already driven; update model at edge, compare after
  task automatic step();
    logic [10:0] cfg;
    bit restart;
    int u, k;
    cfg = {mode, clk_sel, rate};
    restart = !en || (cfg != prev_cfg);
    @(posedge clk);
    cycles++;
    if (restart) begin
      act_idx = 0;
      e_os = 0; e_bit = 0; e_sclk = 0; e_edge = 0;
    end else begin
      u = unit_len(clk_sel, rate);
      k = act_idx + 1;
      if (mode == 1'b0) begin
        e_os = (k % u) == 0;
        e_bit = (k % (16 * u)) == 0;
        e_edge = 0;
        e_sclk = 0;
      end else begin
        e_os = 0;
        e_edge = (k % u) == 0;
        e_bit = (k % (2 * u)) == u;
        if (e_edge) e_sclk = ~e_sclk;
      end
      act_idx++;
    end
    prev_cfg = cfg;
    #1;
    if (!en) begin
      check1("R7 os_tick", os_tick, 1'b0);
      check1("R7 bit_tick", bit_tick, 1'b0);
      check1("R7 sclk", sclk, 1'b0);
      check1("R7 sclk_edge", sclk_edge, 1'b0);
    end else if (restart) begin
      check1("R6 os_tick", os_tick, 1'b0);
      check1("R6 bit_tick", bit_tick, 1'b0);
      check1("R6 sclk", sclk, 1'b0);
      check1("R6 sclk_edge", sclk_edge, 1'b0);
    end else if (mode == 1'b0) begin
      check1("R1 os_tick", os_tick, e_os);
      check1("R3 bit_tick", bit_tick, e_bit);
      check1("R8 sclk", sclk, e_sclk);
      check1("R8 sclk_edge", sclk_edge, e_edge);
    end else begin
      check1((clk_sel == 0 && rate == 0) ? "R9 sclk" : "R4 sclk", sclk, e_sclk);
      check1("R4 sclk_edge", sclk_edge, e_edge);
      check1("R5 bit_tick", bit_tick, e_bit);
      check1("R8 os_tick", os_tick, e_os);
    end
  endtask

  task automatic run_seg(input logic m, input logic [1:0] s, input logic [7:0] n,
                         input bit e, input int len);
    @(negedge clk);
    mode = m; clk_sel = s; rate = n; en = e;
    step();
    for (int c = 1; c < len; c++) begin
      @(negedge clk);
      step();
    end
  endtask

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int u;
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 3);
    // R10 reset state
    check1("R10 os_tick", os_tick, 1'b0);
    check1("R10 bit_tick", bit_tick, 1'b0);
    check1("R10 sclk", sclk, 1'b0);
    check1("R10 sclk_edge", sclk_edge, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    e_sclk = 0;

    // R9 fastest synchronous setting
    run_seg(1'b1, 2'd0, 8'd0, 1'b1, 40);
    // R7 disabled hold
    run_seg(1'b1, 2'd0, 8'd0, 1'b0, 20);
    // R2 largest prescaler, async, bit tick after 16 units
    run_seg(1'b0, 2'd3, 8'd0, 1'b1, 16 * unit_len(2'd3, 8'd0) + 50);
    // R2 prescale 32, sync
    run_seg(1'b1, 2'd2, 8'd1, 1'b1, 4 * unit_len(2'd2, 8'd1) + 10);
    // R1 top rate value, sync
    run_seg(1'b1, 2'd0, 8'd255, 1'b1, 2 * unit_len(2'd0, 8'd255) + 20);
    // R6 change rate mid count, then mode mid count
    run_seg(1'b0, 2'd1, 8'd3, 1'b1, 100);
    run_seg(1'b0, 2'd1, 8'd2, 1'b1, 16 * unit_len(2'd1, 8'd2) + 10);
    run_seg(1'b1, 2'd1, 8'd2, 1'b1, 2 * unit_len(2'd1, 8'd2) + 10);
    // random mix
    for (int r = 0; r < 14; r++) begin
      logic m;
      logic [1:0] s;
      logic [7:0] n;
      m = 1'($urandom % 2);
      s = 2'($urandom % 2);
      n = 8'($urandom % 8);
      u = unit_len(s, n);
      run_seg(m, s, n, 1'b1, (m ? 4 : 17) * u + int'($urandom % 7));
      if ($urandom % 3 == 0) run_seg(m, s, n, 1'b0, 5);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule